// File: doc/BRIEF.md
# Sector Transfer Queue Between Write-Back Cache and System Bus

This block sits between a write-back cache and a burst system bus. The cache hands it two kinds of work. The first is fill requests: a sector address plus the index of the word the processor is waiting for. The second is evicted sectors: a sector address plus all eight 32-bit words, usually the least recently used sector pushed out to make room for a fill. Fills wait in a two-entry read queue and evictions in a three-entry write queue. The block offers one transaction at a time to the bus through a request/grant handshake, followed by eight data beats.

Reads normally go ahead of writes, because a fill stalls the processor and an eviction does not. A full write queue reverses that rule. A read never passes an older write to the same sector. Read bursts begin at the word the cache asked for and wrap within the sector. Each beat is handed to the cache in the cycle it arrives, so the critical word comes back first. A sync pulse sets up an ordering barrier: new work is refused and everything already queued leaves in strict arrival order until both queues are empty.

Top module: `sector_xfer_queue`

## Requirements
- R1: After reset, bus_req_o and rd_valid_o are low, and fill_ready_o and ev_ready_o are high.
- R2: fill_ready_o is low while two fills are queued, and ev_ready_o is low while three evictions are queued.
- R3: A read burst is requested with bus_word_o equal to the fill's word index. Beat k returns word (start + k) mod 8. Each beat appears on rd_valid_o/rd_data_o in the same cycle as bus_beat_i. rd_crit_o marks beat 0 and rd_last_o marks beat 7.
- R4: A write burst is requested with bus_word_o = 0. Beat k drives bus_wdata_o with word k of the evicted sector, taken from ev_data_i bits [32k+31:32k].
- R5: With the write queue not full and no conflict, a queued fill is issued before any queued eviction.
- R6: With three evictions queued, the oldest eviction is issued ahead of any fill.
- R7: A fill whose sector address matches an older queued eviction is not issued until that eviction has been granted. A younger eviction to the same sector does not hold it back. A fill and an eviction accepted in the same cycle count as the fill being older.
- R8: Transactions of the same kind are issued in the order they were accepted.
- R9: From the cycle after sync_i, both ready outputs stay low and transactions issue strictly in acceptance order. The ready outputs return high once both queues are empty and no burst is running.
- R10: bus_req_o stays low from the grant until the eighth beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Fill request valid |
| fill_ready_o | output | 1 | Fill request accepted when high with valid |
| fill_addr_i | input | SA_W | Sector address of the fill |
| fill_word_i | input | log2(SECTOR_WORDS) | Word index wanted first |
| ev_valid_i | input | 1 | Evicted sector valid |
| ev_ready_o | output | 1 | Eviction accepted when high with valid |
| ev_addr_i | input | SA_W | Sector address of the eviction |
| ev_data_i | input | SECTOR_WORDS*DATA_W | Sector data, word k at bits [DATA_W*k +: DATA_W] |
| sync_i | input | 1 | Ordering barrier pulse |
| rd_valid_o | output | 1 | Fill data beat to the cache |
| rd_addr_o | output | SA_W | Sector address of the returning fill |
| rd_word_o | output | log2(SECTOR_WORDS) | Word index of the current beat |
| rd_data_o | output | DATA_W | Returned word |
| rd_crit_o | output | 1 | Beat carries the requested word |
| rd_last_o | output | 1 | Final beat of the fill |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | SA_W | Sector address of the request |
| bus_word_o | output | log2(SECTOR_WORDS) | Starting word of the burst |
| bus_gnt_i | input | 1 | Grant; transaction starts on req and gnt |
| bus_beat_i | input | 1 | One data beat of the running burst |
| bus_rdata_i | input | DATA_W | Read beat data |
| bus_wdata_o | output | DATA_W | Write beat data |

## Verification
The assertions assume the bus grants only while bus_req_o is high. They also assume it delivers exactly eight beats after each grant, with none outside a burst, and that sync_i is a single-cycle pulse. The bench keeps within these limits. It acts as the bus itself: it raises the grant for one cycle only after it sees a request, then drives eight consecutive beats. It offers work to the cache side only when the queue under test should have room, except where refusal is the point of the check. Sector addresses are kept distinct, except in the cases built to create a same-sector conflict.

// File: rtl/sxq_pkg.sv
package sxq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RD   = 2'd1,
    SEL_WR   = 2'd2
  } sxq_sel_e;
endpackage

// File: rtl/sxq_wr_queue.sv
module sxq_wr_queue #(
  parameter int DEPTH = 3,
  parameter int AW    = 27,
  parameter int DW    = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic                pop_i,
  output logic [CW-1:0]       count_o,
  output logic [DEPTH-1:0]    valid_o,
  output logic [DEPTH*AW-1:0] addr_o,
  output logic [DW-1:0]       head_data_o
);
  logic [CW-1:0] cnt_q, slot;

  assign slot    = cnt_q - CW'(pop_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
  end

  // entry 0 is always the oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] a_q, a_src;
    logic [DW-1:0] d_q, d_src;
    if (g < DEPTH - 1) begin : g_shift
      assign a_src = pop_i ? g_ent[g+1].a_q : a_q;
      assign d_src = pop_i ? g_ent[g+1].d_q : d_q;
    end else begin : g_tail
      assign a_src = a_q;
      assign d_src = d_q;
    end
    always_ff @(posedge clk_i) begin
      if (push_i && slot == CW'(g)) begin
        a_q <= addr_i;
        d_q <= data_i;
      end else begin
        a_q <= a_src;
        d_q <= d_src;
      end
    end
    assign addr_o[g*AW +: AW] = a_q;
    assign valid_o[g]         = cnt_q > CW'(g);
  end

  assign head_data_o = g_ent[0].d_q;
endmodule

// File: rtl/sxq_rd_queue.sv
module sxq_rd_queue #(
  parameter int DEPTH = 2,
  parameter int AW    = 27,
  parameter int WW    = 3,
  parameter int KW    = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] word_i,
  input  logic [KW-1:0] ahead_i,
  input  logic          pop_i,
  input  logic          wr_pop_i,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] head_addr_o,
  output logic [WW-1:0] head_word_o,
  output logic [KW-1:0] head_ahead_o
);
  logic [CW-1:0] cnt_q, slot;

  assign slot    = cnt_q - CW'(pop_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
  end

  // k_q counts evictions accepted before this fill and not yet granted
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] a_q, a_src;
    logic [WW-1:0] w_q, w_src;
    logic [KW-1:0] k_q, k_src;
    if (g < DEPTH - 1) begin : g_shift
      assign a_src = pop_i ? g_ent[g+1].a_q : a_q;
      assign w_src = pop_i ? g_ent[g+1].w_q : w_q;
      assign k_src = pop_i ? g_ent[g+1].k_q : k_q;
    end else begin : g_tail
      assign a_src = a_q;
      assign w_src = w_q;
      assign k_src = k_q;
    end
    always_ff @(posedge clk_i) begin
      if (push_i && slot == CW'(g)) begin
        a_q <= addr_i;
        w_q <= word_i;
        k_q <= ahead_i;
      end else begin
        a_q <= a_src;
        w_q <= w_src;
        k_q <= k_src - KW'(wr_pop_i && k_src != '0);
      end
    end
  end

  assign head_addr_o  = g_ent[0].a_q;
  assign head_word_o  = g_ent[0].w_q;
  assign head_ahead_o = g_ent[0].k_q;
endmodule

// File: rtl/sxq_arbiter.sv
module sxq_arbiter
  import sxq_pkg::*;
#(
  parameter int WR_DEPTH = 3,
  parameter int AW       = 27,
  parameter int KW       = 2
) (
  input  logic                   idle_i,
  input  logic                   barrier_i,
  input  logic                   rd_valid_i,
  input  logic [AW-1:0]          rd_addr_i,
  input  logic [KW-1:0]          rd_ahead_i,
  input  logic [WR_DEPTH-1:0]    wr_valid_i,
  input  logic [WR_DEPTH*AW-1:0] wr_addr_i,
  output sxq_sel_e               sel_o
);
  logic [WR_DEPTH-1:0] conflict;
  logic                hazard, wr_any, wr_full;

  // only evictions older than the head fill can block it
  for (genvar g = 0; g < WR_DEPTH; g++) begin : g_cmp
    assign conflict[g] = wr_valid_i[g] && (rd_ahead_i > KW'(g)) &&
                         (wr_addr_i[g*AW +: AW] == rd_addr_i);
  end

  assign hazard  = |conflict;
  assign wr_any  = wr_valid_i[0];
  assign wr_full = wr_valid_i[WR_DEPTH-1];

  always_comb begin
    sel_o = SEL_NONE;
    if (idle_i) begin
      if (barrier_i) begin
        if (rd_valid_i && rd_ahead_i == '0) sel_o = SEL_RD;
        else if (wr_any)                    sel_o = SEL_WR;
      end else if (wr_full) begin
        sel_o = SEL_WR;
      end else if (rd_valid_i && !hazard) begin
        sel_o = SEL_RD;
      end else if (wr_any) begin
        sel_o = SEL_WR;
      end
    end
  end
endmodule

// File: rtl/sxq_burst.sv
module sxq_burst #(
  parameter int AW    = 27,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [IW-1:0]   word_i,
  input  logic [WORDS*DW-1:0] wdata_i,
  input  logic            beat_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            busy_o,
  output logic [DW-1:0]   wdata_o,
  output logic            rd_valid_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [IW-1:0]   rd_word_o,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_crit_o,
  output logic            rd_last_o
);
  logic              busy_q, we_q;
  logic [AW-1:0]     addr_q;
  logic [IW-1:0]     st_q, cnt_q, idx;
  logic [WORDS*DW-1:0] buf_q;
  logic              last_beat;

  assign idx       = st_q + cnt_q;  // wraps inside the sector
  assign last_beat = cnt_q == IW'(WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && beat_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      we_q   <= we_i;
      addr_q <= addr_i;
      st_q   <= word_i;
      buf_q  <= wdata_i;
    end
  end

  assign busy_o     = busy_q;
  assign wdata_o    = buf_q[idx*DW +: DW];
  assign rd_valid_o = busy_q && !we_q && beat_i;
  assign rd_addr_o  = addr_q;
  assign rd_word_o  = idx;
  assign rd_data_o  = rdata_i;
  assign rd_crit_o  = cnt_q == '0;
  assign rd_last_o  = last_beat;
endmodule

// File: rtl/sector_xfer_queue.sv
module sector_xfer_queue
  import sxq_pkg::*;
#(
  parameter int SA_W         = 27,
  parameter int DATA_W       = 32,
  parameter int SECTOR_WORDS = 8,
  parameter int RD_DEPTH     = 2,
  parameter int WR_DEPTH     = 3,
  localparam int WI_W        = $clog2(SECTOR_WORDS),
  localparam int SEC_W       = SECTOR_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  output logic              fill_ready_o,
  input  logic [SA_W-1:0]   fill_addr_i,
  input  logic [WI_W-1:0]   fill_word_i,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic [SA_W-1:0]   ev_addr_i,
  input  logic [SEC_W-1:0]  ev_data_i,
  input  logic              sync_i,
  output logic              rd_valid_o,
  output logic [SA_W-1:0]   rd_addr_o,
  output logic [WI_W-1:0]   rd_word_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_crit_o,
  output logic              rd_last_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [SA_W-1:0]   bus_addr_o,
  output logic [WI_W-1:0]   bus_word_o,
  input  logic              bus_gnt_i,
  input  logic              bus_beat_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] bus_wdata_o
);
  localparam int RC_W = $clog2(RD_DEPTH + 1);
  localparam int WC_W = $clog2(WR_DEPTH + 1);

  logic [RC_W-1:0]          rd_cnt;
  logic [WC_W-1:0]          wr_cnt, ahead_in, rd_ahead;
  logic [WR_DEPTH-1:0]      wr_valid;
  logic [WR_DEPTH*SA_W-1:0] wr_addr;
  logic [SEC_W-1:0]         wr_head_data;
  logic [SA_W-1:0]          rd_head_addr;
  logic [WI_W-1:0]          rd_head_word;
  logic                     fill_acc, ev_acc, start, rd_pop, wr_pop;
  logic                     busy, bar_q, drained;
  sxq_sel_e                 sel;

  assign fill_ready_o = (rd_cnt < RC_W'(RD_DEPTH)) && !bar_q;
  assign ev_ready_o   = (wr_cnt < WC_W'(WR_DEPTH)) && !bar_q;
  assign fill_acc     = fill_valid_i && fill_ready_o;
  assign ev_acc       = ev_valid_i && ev_ready_o;

  assign bus_req_o  = sel != SEL_NONE;
  assign bus_we_o   = sel == SEL_WR;
  assign bus_addr_o = bus_we_o ? wr_addr[SA_W-1:0] : rd_head_addr;
  assign bus_word_o = bus_we_o ? '0 : rd_head_word;

  assign start  = bus_req_o && bus_gnt_i;
  assign rd_pop = start && !bus_we_o;
  assign wr_pop = start && bus_we_o;

  // a same-cycle eviction is younger than the fill
  assign ahead_in = wr_cnt - WC_W'(wr_pop);
  assign drained  = rd_cnt == '0 && wr_cnt == '0 && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               bar_q <= 1'b0;
    else if (sync_i)           bar_q <= 1'b1;
    else if (bar_q && drained) bar_q <= 1'b0;
  end

  sxq_rd_queue #(
    .DEPTH (RD_DEPTH),
    .AW    (SA_W),
    .WW    (WI_W),
    .KW    (WC_W)
  ) u_rdq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (fill_acc),
    .addr_i       (fill_addr_i),
    .word_i       (fill_word_i),
    .ahead_i      (ahead_in),
    .pop_i        (rd_pop),
    .wr_pop_i     (wr_pop),
    .count_o      (rd_cnt),
    .head_addr_o  (rd_head_addr),
    .head_word_o  (rd_head_word),
    .head_ahead_o (rd_ahead)
  );

  sxq_wr_queue #(
    .DEPTH (WR_DEPTH),
    .AW    (SA_W),
    .DW    (SEC_W)
  ) u_wrq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ev_acc),
    .addr_i      (ev_addr_i),
    .data_i      (ev_data_i),
    .pop_i       (wr_pop),
    .count_o     (wr_cnt),
    .valid_o     (wr_valid),
    .addr_o      (wr_addr),
    .head_data_o (wr_head_data)
  );

  sxq_arbiter #(
    .WR_DEPTH (WR_DEPTH),
    .AW       (SA_W),
    .KW       (WC_W)
  ) u_arb (
    .idle_i     (!busy),
    .barrier_i  (bar_q),
    .rd_valid_i (rd_cnt != '0),
    .rd_addr_i  (rd_head_addr),
    .rd_ahead_i (rd_ahead),
    .wr_valid_i (wr_valid),
    .wr_addr_i  (wr_addr),
    .sel_o      (sel)
  );

  sxq_burst #(
    .AW    (SA_W),
    .DW    (DATA_W),
    .WORDS (SECTOR_WORDS)
  ) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .we_i       (bus_we_o),
    .addr_i     (bus_addr_o),
    .word_i     (bus_word_o),
    .wdata_i    (wr_head_data),
    .beat_i     (bus_beat_i),
    .rdata_i    (bus_rdata_i),
    .busy_o     (busy),
    .wdata_o    (bus_wdata_o),
    .rd_valid_o (rd_valid_o),
    .rd_addr_o  (rd_addr_o),
    .rd_word_o  (rd_word_o),
    .rd_data_o  (rd_data_o),
    .rd_crit_o  (rd_crit_o),
    .rd_last_o  (rd_last_o)
  );
endmodule

// File: rtl/sxq_checker.sv
module sxq_checker #(
  parameter int WI_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sync_i,
  input logic            fill_ready_o,
  input logic            ev_ready_o,
  input logic            bus_req_o,
  input logic            bus_we_o,
  input logic [WI_W-1:0] bus_word_o,
  input logic            bus_gnt_i,
  input logic            bus_beat_i,
  input logic            rd_valid_o,
  input logic [WI_W-1:0] rd_word_o,
  input logic            rd_crit_o
);
  logic            act_q;
  logic [WI_W-1:0] st_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      st_q  <= '0;
      cnt_q <= '0;
    end else if (bus_req_o && bus_gnt_i) begin
      act_q <= 1'b1;
      st_q  <= bus_word_o;
      cnt_q <= '0;
    end else if (act_q && bus_beat_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) act_q <= 1'b0;
    end
  end

  p_no_req_in_burst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> !bus_req_o);

  p_wrap_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_word_o == WI_W'(st_q + cnt_q)) && (rd_crit_o == (cnt_q == '0)));

  p_beat_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> act_q && bus_beat_i);

  p_wr_from_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> bus_word_o == '0);

  p_sync_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !fill_ready_o && !ev_ready_o);
endmodule

bind sector_xfer_queue sxq_checker #(.WI_W($clog2(SECTOR_WORDS))) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_i       (sync_i),
  .fill_ready_o (fill_ready_o),
  .ev_ready_o   (ev_ready_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_word_o   (bus_word_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_beat_i   (bus_beat_i),
  .rd_valid_o   (rd_valid_o),
  .rd_word_o    (rd_word_o),
  .rd_crit_o    (rd_crit_o)
);

// File: tb/sector_xfer_queue_tb.sv
module sector_xfer_queue_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_valid = 1'b0, ev_valid = 1'b0, sync = 1'b0;
  logic [26:0]  fill_addr = '0, ev_addr = '0;
  logic [2:0]   fill_word = '0;
  logic [255:0] ev_data = '0;
  logic         gnt = 1'b0, beat = 1'b0;
  logic [31:0]  rdata = '0;
  logic         fill_ready, ev_ready, rd_valid, rd_crit, rd_last;
  logic [26:0]  rd_addr, bus_addr;
  logic [2:0]   rd_word, bus_word;
  logic [31:0]  rd_data, wdata;
  logic         req, we;
  int           n_chk = 0, n_err = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  sector_xfer_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_ready_o(fill_ready),
    .fill_addr_i(fill_addr), .fill_word_i(fill_word),
    .ev_valid_i(ev_valid), .ev_ready_o(ev_ready),
    .ev_addr_i(ev_addr), .ev_data_i(ev_data), .sync_i(sync),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_word_o(rd_word),
    .rd_data_o(rd_data), .rd_crit_o(rd_crit), .rd_last_o(rd_last),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(bus_addr),
    .bus_word_o(bus_word), .bus_gnt_i(gnt), .bus_beat_i(beat),
    .bus_rdata_i(rdata), .bus_wdata_o(wdata)
  );

  function automatic logic [31:0] memw(logic [26:0] a, logic [2:0] i);
    return {a[20:0], 8'h5A, i};
  endfunction

  function automatic logic [31:0] evw(logic [26:0] a, logic [2:0] k);
    return {a[20:0], 8'hC3, k};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle on the cache side; f/e select which request is offered
  task automatic push(input bit f, input logic [26:0] fa, input logic [2:0] fw,
                      input bit e, input logic [26:0] ea);
    fill_valid = f; fill_addr = fa; fill_word = fw;
    ev_valid = e; ev_addr = ea;
    for (int k = 0; k < 8; k++) ev_data[k*32 +: 32] = evw(ea, 3'(k));
    @(negedge clk);
    fill_valid = 1'b0; ev_valid = 1'b0;
  endtask

  // bus model: grant the pending request and run eight beats
  task automatic serve(input bit xwe, input logic [26:0] xa, input logic [2:0] xw, input string tag);
    int t = 0;
    while (!req && t < 40) begin @(negedge clk); t++; end
    chk(req && we == xwe && bus_addr == xa && bus_word == xw, tag,
        {32'(req), 1'b0, we, bus_addr, bus_word}, {32'd1, 1'b0, xwe, xa, xw});
    if (!req) return;
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk(!req, "R10 req during burst", 64'(req), 64'd0);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] ix;
      ix = xw + 3'(k);
      beat = 1'b1; rdata = memw(xa, ix);
      #1;
      if (xwe)
        chk(wdata == evw(xa, 3'(k)), "R4 write beat", 64'(wdata), 64'(evw(xa, 3'(k))));
      else
        chk({rd_valid, rd_word, rd_crit, rd_last, rd_data, rd_addr} ==
            {1'b1, ix, k == 0, k == 7, memw(xa, ix), xa},
            "R3 read beat",
            64'({rd_valid, rd_word, rd_crit, rd_last, rd_data}),
            64'({1'b1, ix, k == 0, k == 7, memw(xa, ix)}));
      @(negedge clk);
    end
    beat = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({req, rd_valid, fill_ready, ev_ready} == 4'b0011, "R1 reset",
        64'({req, rd_valid, fill_ready, ev_ready}), 64'b0011);

    // R3 every start word
    for (int w = 0; w < 8; w++) begin
      push(1, 27'(16 + w), 3'(w), 0, '0);
      serve(0, 27'(16 + w), 3'(w), "R3 read request");
    end

    // R4 single eviction
    push(0, '0, '0, 1, 27'h1234);
    serve(1, 27'h1234, 3'd0, "R4 write request");

    // R5 read passes older unrelated write
    push(0, '0, '0, 1, 27'd40);
    push(1, 27'd41, 3'd2, 0, '0);
    serve(0, 27'd41, 3'd2, "R5 read first");
    serve(1, 27'd40, 3'd0, "R5 write second");

    // R7 read waits for older write to same sector
    push(0, '0, '0, 1, 27'd50);
    push(1, 27'd50, 3'd5, 0, '0);
    serve(1, 27'd50, 3'd0, "R7 older write first");
    serve(0, 27'd50, 3'd5, "R7 read after write");

    // R7 younger write to same sector does not block
    push(1, 27'd60, 3'd1, 0, '0);
    push(0, '0, '0, 1, 27'd60);
    serve(0, 27'd60, 3'd1, "R7 older read first");
    serve(1, 27'd60, 3'd0, "R7 younger write");

    // R7 same-cycle pair: fill counts as older
    push(1, 27'd70, 3'd6, 1, 27'd70);
    serve(0, 27'd70, 3'd6, "R7 same cycle read first");
    serve(1, 27'd70, 3'd0, "R7 same cycle write");

    // R2 / R6 full write queue
    push(0, '0, '0, 1, 27'd81);
    push(0, '0, '0, 1, 27'd82);
    push(0, '0, '0, 1, 27'd83);
    chk(ev_ready == 1'b0, "R2 write queue full", 64'(ev_ready), 64'd0);
    push(1, 27'd84, 3'd3, 0, '0);
    serve(1, 27'd81, 3'd0, "R6 oldest write first");
    serve(0, 27'd84, 3'd3, "R5 read after full relief");
    serve(1, 27'd82, 3'd0, "R8 write order");
    serve(1, 27'd83, 3'd0, "R8 write order");

    // R2 / R8 full read queue
    push(1, 27'd91, 3'd7, 0, '0);
    push(1, 27'd92, 3'd0, 0, '0);
    chk(fill_ready == 1'b0, "R2 read queue full", 64'(fill_ready), 64'd0);
    serve(0, 27'd91, 3'd7, "R8 read order");
    serve(0, 27'd92, 3'd0, "R8 read order");

    // R9 barrier restores acceptance order
    push(0, '0, '0, 1, 27'd101);
    push(1, 27'd102, 3'd1, 0, '0);
    push(0, '0, '0, 1, 27'd103);
    push(1, 27'd104, 3'd2, 0, '0);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    chk({fill_ready, ev_ready} == 2'b00, "R9 stall", 64'({fill_ready, ev_ready}), 64'd0);
    serve(1, 27'd101, 3'd0, "R9 order 1");
    serve(0, 27'd102, 3'd1, "R9 order 2");
    chk({fill_ready, ev_ready} == 2'b00, "R9 stall mid", 64'({fill_ready, ev_ready}), 64'd0);
    serve(1, 27'd103, 3'd0, "R9 order 3");
    serve(0, 27'd104, 3'd2, "R9 order 4");
    repeat (2) @(negedge clk);
    chk({fill_ready, ev_ready} == 2'b11, "R9 release", 64'({fill_ready, ev_ready}), 64'b11);

    // R5 R6 R8 sweep over queue occupancies
    for (int nw = 0; nw <= 3; nw++) begin
      for (int nr = 0; nr <= 2; nr++) begin
        int wc, rc, wi, ri;
        for (int i = 0; i < nw; i++) push(0, '0, '0, 1, 27'(200 + i));
        for (int j = 0; j < nr; j++) push(1, 27'(300 + j), 3'(j * 3), 0, '0);
        wc = nw; rc = nr; wi = 0; ri = 0;
        for (int s = 0; s < nw + nr; s++) begin
          if (wc == 3 || rc == 0) begin
            serve(1, 27'(200 + wi), 3'd0, "R6 sweep order");
            wi++; wc--;
          end else begin
            serve(0, 27'(300 + ri), 3'(ri * 3), "R5 sweep order");
            ri++; rc--;
          end
        end
      end
    end

    @(negedge clk);
    chk(req == 1'b0, "R8 queues empty", 64'(req), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule